// File: doc/BRIEF.md
# Descriptor-Ring Byte Transmitter

This engine feeds a serial shifter from a ring of transmit descriptors that a host keeps in shared memory. Each 8-byte descriptor holds a 16-bit control word, a 16-bit byte count and a 32-bit buffer address. The engine reads a descriptor. If the host has marked it ready, the engine reads the buffer one byte at a time and presents each byte on a valid/ready stream. When the buffer ends, the engine writes the control word back, which hands ownership back to the host.

The walk begins at the table base when the engine is enabled. It advances 8 bytes per descriptor and jumps back to the base after a descriptor that carries the wrap flag, so the host sets the ring length by where it places that flag. The shifter reports starvation through an underrun input, which ends the current buffer with an error mark. The engine then raises a sticky event, which the host acknowledges by writing 1 to it. Each event is masked separately onto one interrupt line.

Top module: `bd_ring_tx`

## Requirements
- R1: While reset is high and just after it is released, tx_valid, mem_req, irq, evt_tx and evt_txe are all 0.
- R2: The engine fetches a descriptor as four halfword reads at descriptor address +0 (control), +2 (byte count), +4 (address bits 31:16) and +6 (address bits 15:0). The memory returns read data one cycle after the request. In the control word, bit 15 is ready, bit 13 is wrap, bit 12 is interrupt request, bit 11 is end-of-frame and bit 9 is continuous. Bit 1 is the underrun mark, and bits 14, 10, 8:2 and 0 are reserved.
- R3: A descriptor whose ready bit is 0 produces no bytes and no write. The engine reads its control word again until the host sets ready, then serves it.
- R4: The buffer's bytes are sent in address order, exactly byte-count bytes. The byte at an even address comes from bits 15:8 of its halfword and the byte at an odd address from bits 7:0. tx_data is held stable while tx_valid waits for tx_ready.
- R5: When the engine closes a descriptor, it writes the control word back to descriptor offset 0. The write keeps wrap, interrupt request, end-of-frame and continuous, clears ready, and zeroes every reserved bit. No byte is offered during that write.
- R6: After a descriptor with wrap set, the next fetch is at tbase. Otherwise it is at the closed descriptor's address plus 8.
- R7: Closing a descriptor that has interrupt request set raises evt_tx (no error) or evt_txe (underrun). Without interrupt request, no event is raised. Events stay set until the matching bit of evt_clr is pulsed high.
- R8: irq is high exactly when a raised event has its evt_mask bit set (bit 0 for evt_tx, bit 1 for evt_txe).
- R9: An underrun seen while a buffer is being read or offered stops that buffer at once. Its write-back has the underrun mark set and ready cleared, and the walk then advances.
- R10: A byte count of zero closes the descriptor without offering any byte.
- R11: With continuous set and no underrun, the write-back keeps ready set.
- R12: tx_last is high together with tx_valid on the final byte of a buffer whose end-of-frame bit is set, and is low on every other byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable; a rising start loads the walk from tbase |
| tbase | input | 32 | Byte address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write strobe, qualifies mem_req |
| mem_addr | output | 32 | Byte address, halfword aligned |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| tx_data | output | 8 | Byte toward the shifter |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | Shifter accepts the byte |
| tx_last | output | 1 | Final byte of an end-of-frame buffer |
| underrun | input | 1 | Shifter starved; abort the current buffer |
| evt_clr | input | 2 | Write-1-to-clear pulses for {evt_txe, evt_tx} |
| evt_mask | input | 2 | Interrupt enables for {evt_txe, evt_tx} |
| evt_tx | output | 1 | Sticky buffer-done event |
| evt_txe | output | 1 | Sticky buffer-error event |
| irq | output | 1 | Masked event interrupt |

## Verification
A stuck or wrong walk pointer shows within one descriptor. The control word is written back to the wrong slot, or the next buffer is never served, and the bench compares every write-back address against the slot it armed. A byte-count or pointer register that slips by one shows as a short, long or shifted byte string, or as a misplaced end-of-frame flag, on the very buffer that went wrong. A corrupted error flag shows in the same buffer's write-back word and event bits, two cycles after the write.

// File: rtl/bd_ring_tx_pkg.sv
package bd_ring_tx_pkg;
    parameter int ADDR_W   = 32;
    parameter int HALF_W   = 16;
    parameter int BYTE_W   = 8;
    parameter int CNT_W    = 16;
    parameter int BD_BYTES = 8;
    parameter int N_EVT    = 2;

    localparam int FLD_W = $clog2(BD_BYTES / 2);

    // control word bit positions (word numbering, bit 15 = most significant)
    localparam int B_RDY  = 15;
    localparam int B_WRAP = 13;
    localparam int B_INT  = 12;
    localparam int B_LAST = 11;
    localparam int B_CM   = 9;
    localparam int B_UN   = 1;

    localparam logic [HALF_W-1:0] RSV_MASK = 16'h45FD;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_FCAP, S_DRQ, S_DCAP, S_SEND, S_CLOSE
    } state_e;

    typedef struct packed {
        logic rdy;
        logic wrap;
        logic intr;
        logic last;
        logic cm;
    } ctl_t;

    function automatic logic [HALF_W-1:0] close_word(input ctl_t c, input logic err);
        logic [HALF_W-1:0] w;
        w         = '0;
        w[B_RDY]  = c.rdy & c.cm & ~err;
        w[B_WRAP] = c.wrap;
        w[B_INT]  = c.intr;
        w[B_LAST] = c.last;
        w[B_CM]   = c.cm;
        w[B_UN]   = err;
        return w;
    endfunction
endpackage

// File: rtl/bd_ring_tx_evt.sv
module bd_ring_tx_evt
    import bd_ring_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] set,
    input  logic [N_EVT-1:0] clr,
    input  logic [N_EVT-1:0] mask,
    output logic [N_EVT-1:0] evt,
    output logic             irq
);
    logic [N_EVT-1:0] evt_q;

    for (genvar g = 0; g < N_EVT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                evt_q[g] <= 1'b0;
            else if (set[g])
                evt_q[g] <= 1'b1;
            else if (clr[g])
                evt_q[g] <= 1'b0;
        end
    end

    assign evt = evt_q;
    assign irq = |(evt_q & mask);
endmodule

// File: rtl/bd_ring_tx_seq.sv
module bd_ring_tx_seq
    import bd_ring_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] tbase,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HALF_W-1:0] mem_wdata,
    input  logic [HALF_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    input  logic              underrun,
    output logic              done_ok,
    output logic              done_err
);
    state_e            state;
    logic [FLD_W-1:0]  fidx;
    logic [ADDR_W-1:0] bd_addr;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  rem;
    logic [BYTE_W-1:0] byte_q;
    logic              err;
    ctl_t              ctl;

    logic [BYTE_W-1:0] lane;
    assign lane = ptr[0] ? mem_rdata[BYTE_W-1:0] : mem_rdata[HALF_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            fidx    <= '0;
            bd_addr <= '0;
            ptr     <= '0;
            rem     <= '0;
            byte_q  <= '0;
            err     <= 1'b0;
            ctl     <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (en) begin
                    bd_addr <= tbase;
                    fidx    <= '0;
                    state   <= S_FETCH;
                end
                S_FETCH: state <= S_FCAP;
                S_FCAP: begin
                    unique case (fidx)
                        2'd0: begin
                            ctl <= '{rdy:  mem_rdata[B_RDY],  wrap: mem_rdata[B_WRAP],
                                     intr: mem_rdata[B_INT],  last: mem_rdata[B_LAST],
                                     cm:   mem_rdata[B_CM]};
                            if (!mem_rdata[B_RDY])
                                state <= en ? S_FETCH : S_IDLE;
                            else begin
                                fidx  <= fidx + 1'b1;
                                state <= S_FETCH;
                            end
                        end
                        2'd1: begin
                            rem   <= mem_rdata;
                            fidx  <= fidx + 1'b1;
                            state <= S_FETCH;
                        end
                        2'd2: begin
                            ptr[ADDR_W-1:HALF_W] <= mem_rdata;
                            fidx  <= fidx + 1'b1;
                            state <= S_FETCH;
                        end
                        default: begin
                            ptr[HALF_W-1:0] <= mem_rdata;
                            err   <= 1'b0;
                            state <= (rem == '0) ? S_CLOSE : S_DRQ;
                        end
                    endcase
                end
                S_DRQ: begin
                    if (underrun) begin err <= 1'b1; state <= S_CLOSE; end
                    else state <= S_DCAP;
                end
                S_DCAP: begin
                    byte_q <= lane;
                    if (underrun) begin err <= 1'b1; state <= S_CLOSE; end
                    else state <= S_SEND;
                end
                S_SEND: begin
                    if (underrun) begin
                        err   <= 1'b1;
                        state <= S_CLOSE;
                    end else if (tx_ready) begin
                        ptr   <= ptr + 1'b1;
                        rem   <= rem - 1'b1;
                        state <= (rem == CNT_W'(1)) ? S_CLOSE : S_DRQ;
                    end
                end
                S_CLOSE: begin
                    bd_addr <= ctl.wrap ? tbase : bd_addr + ADDR_W'(BD_BYTES);
                    fidx    <= '0;
                    state   <= en ? S_FETCH : S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (state == S_FETCH) || (state == S_DRQ) || (state == S_CLOSE);
        mem_we   = (state == S_CLOSE);
        mem_addr = bd_addr;
        if (state == S_FETCH)
            mem_addr = bd_addr + ADDR_W'({fidx, 1'b0});
        else if (state == S_DRQ)
            mem_addr = {ptr[ADDR_W-1:1], 1'b0};
        mem_wdata = close_word(ctl, err);
    end

    assign tx_data  = byte_q;
    assign tx_valid = (state == S_SEND) && !underrun;
    assign tx_last  = tx_valid && ctl.last && (rem == CNT_W'(1));
    assign done_ok  = (state == S_CLOSE) && ctl.intr && !err;
    assign done_err = (state == S_CLOSE) && ctl.intr && err;
endmodule

// File: rtl/bd_ring_tx.sv
module bd_ring_tx
    import bd_ring_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] tbase,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HALF_W-1:0] mem_wdata,
    input  logic [HALF_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    input  logic              underrun,
    input  logic [N_EVT-1:0]  evt_clr,
    input  logic [N_EVT-1:0]  evt_mask,
    output logic              evt_tx,
    output logic              evt_txe,
    output logic              irq
);
    logic             done_ok, done_err;
    logic [N_EVT-1:0] evt;

    bd_ring_tx_seq u_seq (
        .clk(clk), .rst(rst), .en(en), .tbase(tbase),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .underrun(underrun),
        .done_ok(done_ok), .done_err(done_err)
    );

    bd_ring_tx_evt u_evt (
        .clk(clk), .rst(rst),
        .set({done_err, done_ok}), .clr(evt_clr), .mask(evt_mask),
        .evt(evt), .irq(irq)
    );

    assign evt_tx  = evt[0];
    assign evt_txe = evt[1];
endmodule

// File: rtl/bd_ring_tx_chk.sv
module bd_ring_tx_chk
    import bd_ring_tx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [HALF_W-1:0] mem_wdata,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic              underrun,
    input logic [N_EVT-1:0]  evt_clr,
    input logic              evt_tx,
    input logic              evt_txe
);
    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !underrun |=> (tx_valid || underrun) && $stable(tx_data));

    // R5
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> (mem_wdata & RSV_MASK) == '0);

    // R5
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !tx_valid);

    // R9
    un_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_wdata[B_UN] |-> !mem_wdata[B_RDY]);

    // R7
    tx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        evt_tx && !evt_clr[0] |=> evt_tx);

    // R7
    txe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        evt_txe && !evt_clr[1] |=> evt_txe);

    // R12
    last_in_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);
endmodule

bind bd_ring_tx bd_ring_tx_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .underrun(underrun),
    .evt_clr(evt_clr), .evt_tx(evt_tx), .evt_txe(evt_txe)
);

// File: tb/bd_ring_tx_tb.sv
module bd_ring_tx_tb;
    localparam logic [31:0] TBASE = 32'h40;
    localparam logic [15:0] RSV   = 16'h45FD;
    localparam int NV = 8;
    // {control flags, byte count, buffer address, stall}
    localparam logic [39:0] VEC [0:NV-1] = '{
        {16'h1000, 8'd3, 8'h81, 8'd0},
        {16'h1800, 8'd4, 8'h90, 8'd1},
        {16'h0000, 8'd2, 8'hA0, 8'd0},
        {16'h1000, 8'd0, 8'hB0, 8'd0},
        {16'h1800, 8'd5, 8'hC3, 8'd1},
        {16'h1504, 8'd1, 8'hD0, 8'd0},
        {16'h1200, 8'd2, 8'hE0, 8'd1},
        {16'h1000, 8'd1, 8'hF0, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic        underrun = 1'b0;
    logic [1:0]  evt_clr = 2'b00;
    logic [1:0]  evt_mask = 2'b01;
    logic        evt_tx, evt_txe, irq;

    always #5 clk = ~clk;

    bd_ring_tx u_dut (
        .clk(clk), .rst(rst), .en(en), .tbase(TBASE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .underrun(underrun),
        .evt_clr(evt_clr), .evt_mask(evt_mask),
        .evt_tx(evt_tx), .evt_txe(evt_txe), .irq(irq)
    );

    // shared memory model: 256 halfwords, one-cycle read latency
    logic [15:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_req && mem_we)
            mem[mem_addr[8:1]] <= mem_wdata;
        else if (mem_req)
            mem_rdata <= mem[mem_addr[8:1]];
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    int          nchk = 0, nfail = 0;
    int          wr_cnt = 0;
    logic [31:0] wr_addr;
    logic [15:0] wr_data;
    logic [7:0]  rx [0:31];
    logic        rxl [0:31];
    int          rx_n = 0;
    logic        stall = 1'b0, hold_off = 1'b0;

    // monitor: drive tx_ready for the coming edge, then log what that edge takes
    always @(negedge clk) begin
        if (hold_off)   tx_ready = 1'b0;
        else if (stall) tx_ready = ~tx_ready;
        else            tx_ready = 1'b1;
        if (tx_valid && tx_ready && rx_n < 32) begin
            rx[rx_n]  = tx_data;
            rxl[rx_n] = tx_last;
            rx_n++;
        end
        if (mem_req && mem_we) begin
            wr_addr = mem_addr;
            wr_data = mem_wdata;
            wr_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_write(input int start);
        int t = 0;
        while (wr_cnt == start && t < 3000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = (w < 64) ? 16'h0000 : {pat(2*w), pat(2*w+1)};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 tx_valid", {31'd0, tx_valid}, 0);
        check("R1 irq/evt", {29'd0, irq, evt_txe, evt_tx}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mem_req idle", {31'd0, mem_req}, 0);

        // R3: nothing ready, engine only polls
        en = 1'b1;
        repeat (50) @(negedge clk);
        check("R3 no write while not ready", wr_cnt, 0);
        check("R3 no byte while not ready", rx_n, 0);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] fl, cin, exp;
            int len, ptr, slot, dw, start;
            fl   = VEC[i][39:24];
            len  = int'(VEC[i][23:16]);
            ptr  = int'(VEC[i][15:8]);
            slot = i % 4;
            dw   = (int'(TBASE) + 8*slot) / 2;
            cin  = fl | ((slot == 3) ? 16'h2000 : 16'h0000) | 16'h8000;
            exp  = cin & ~RSV;
            if (!fl[9]) exp[15] = 1'b0;
            @(negedge clk);
            stall = VEC[i][0];
            rx_n  = 0;
            start = wr_cnt;
            mem[dw+1] = 16'(len);
            mem[dw+2] = 16'h0000;
            mem[dw+3] = 16'(ptr);
            mem[dw]   = cin;
            wait_write(start);
            // R2 R6: write-back lands on the armed slot after wrap/advance
            check("R6 write-back address", wr_addr, TBASE + 32'(8*slot));
            // R5 R11: returned control word
            check("R5/R11 write-back word", {16'd0, wr_data}, {16'd0, exp});
            // R4 R10: byte count
            check("R4/R10 byte count", rx_n, len);
            for (int k = 0; k < len && k < rx_n; k++) begin
                check("R4 byte value", {24'd0, rx[k]}, {24'd0, pat(ptr + k)});
                check("R12 end flag", {31'd0, rxl[k]},
                      {31'd0, (fl[11] && k == len - 1)});
            end
            // R7 R8
            check("R7 events", {30'd0, evt_txe, evt_tx}, {30'd0, 1'b0, fl[12]});
            check("R8 irq", {31'd0, irq}, {31'd0, fl[12]});
            evt_clr = 2'b11;
            @(negedge clk);
            evt_clr = 2'b00;
        end

        // R9: underrun aborts a buffer at slot 0
        begin
            int start, t;
            @(negedge clk);
            stall = 1'b0;
            hold_off = 1'b1;
            rx_n = 0;
            start = wr_cnt;
            mem[(int'(TBASE))/2 + 1] = 16'd6;
            mem[(int'(TBASE))/2 + 2] = 16'h0000;
            mem[(int'(TBASE))/2 + 3] = 16'h0100;
            mem[(int'(TBASE))/2]     = 16'h9000;
            t = 0;
            while (!tx_valid && t < 3000) begin @(negedge clk); t++; end
            underrun = 1'b1;
            @(negedge clk);
            underrun = 1'b0;
            wait_write(start);
            hold_off = 1'b0;
            check("R9 write-back word", {16'd0, wr_data}, 32'h1002);
            check("R9 address", wr_addr, TBASE);
            check("R9 no byte sent", rx_n, 0);
            check("R7 error event", {30'd0, evt_txe, evt_tx}, 2);
            evt_mask = 2'b01;
            @(negedge clk);
            check("R8 masked error", {31'd0, irq}, 0);
            evt_mask = 2'b10;
            repeat (5) @(negedge clk);
            check("R8 enabled error", {31'd0, irq}, 1);
            check("R7 sticky", {31'd0, evt_txe}, 1);
            evt_clr = 2'b01;
            @(negedge clk);
            evt_clr = 2'b00;
            @(negedge clk);
            check("R7 clear other bit leaves txe", {31'd0, evt_txe}, 1);
            evt_clr = 2'b10;
            @(negedge clk);
            evt_clr = 2'b00;
            @(negedge clk);
            check("R7 cleared", {30'd0, evt_txe, evt_tx}, 0);
            check("R8 irq cleared", {31'd0, irq}, 0);
        end
        summary();
    end
endmodule